// File: doc/BRIEF.md
# Graphics Engine Interrupt Status and Enable Controller

This block gathers three interrupt causes of a graphics engine and presents them to software as a small register file on a simple read/write bus. The causes are the binner running out of memory, the binner finishing its flush, and the renderer finishing a frame. A status register shows which causes are pending. Software clears a pending cause by writing 1 to its bit. The enable mask cannot be written as a whole. It is changed through two aliased addresses: one only turns bits on, the other only turns bits off. Both addresses read back the current mask.

The flush-done and frame-done causes arrive as single-cycle pulses and are held until software clears them. The out-of-memory cause is a level from the binner, so its pending bit cannot be cleared while that level is high. A driver masks it through the disable address while it supplies new memory, then unmasks it. A single registered interrupt line rises while any pending bit is also enabled.

Top module: `gfx_irq_ctrl`

## Requirements
- R1: While rst_ni is low, and on leaving reset, all pending bits and all enable bits are 0 and irq_o is 0.
- R2: Register offsets are: status 0x0, set-enable 0x4, clear-enable 0x8. Bit positions in all three are: frame done at bit 0, flush done at bit 1, out-of-memory at bit 3. Bit 2, bits above 3, and reads of any other offset return 0.
- R3: A one-cycle pulse on flush_done_i or frame_done_i sets its pending bit. The bit stays set until it is cleared by a write of 1. Writing 0 to it has no effect.
- R4: Writing 1 to a status bit clears it, unless that source is active in the same cycle. In that case the bit stays set.
- R5: While oom_i is high, the out-of-memory pending bit reads 1, even directly after a write-1 clear. After oom_i falls, the bit stays set until it is cleared.
- R6: A write to the set-enable offset turns on each enable bit written as 1. Bits written as 0 keep their value.
- R7: A write to the clear-enable offset turns off each enable bit written as 1. Bits written as 0 keep their value.
- R8: A read of the set-enable offset and a read of the clear-enable offset both return the current enable mask.
- R9: Pending bits latch whether or not their source is enabled.
- R10: irq_o is a register. It is 1 in the cycle after any bit is both pending and enabled, and 0 otherwise.
- R11: A read request returns its data on rdata_o with rvalid_o high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus request strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset of the register |
| wdata_i | input | DATA_W | Write data |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | DATA_W | Read data |
| oom_i | input | 1 | Binner out-of-memory level |
| flush_done_i | input | 1 | Binner flush-done pulse |
| frame_done_i | input | 1 | Render frame-done pulse |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check several rules on every cycle. A pending bit that is not cleared stays set, and an active source always leaves its bit set. Set-enable and clear-enable writes act only on the bits written as 1. irq_o follows the pending-and-enabled condition one cycle later, and unused read bits are zero. Other rules appear only as sequences in the bench scenarios. These are: a clear racing a new event, a clear of the out-of-memory bit that fails while the level is high and works after it falls, masking during memory supply, and the two enable aliases reading back the same mask.

// File: rtl/gfx_irq_pkg.sv
package gfx_irq_pkg;
  localparam int unsigned SRC_W     = 4;
  localparam int unsigned BIT_FRAME = 0;
  localparam int unsigned BIT_FLUSH = 1;
  localparam int unsigned BIT_OOM   = 3;
  localparam logic [SRC_W-1:0] SRC_MASK = 4'b1011;

  localparam int unsigned OFF_STAT = 'h0;
  localparam int unsigned OFF_ENA  = 'h4;
  localparam int unsigned OFF_DIS  = 'h8;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_STAT,
    SEL_ENA,
    SEL_DIS
  } reg_sel_e;
endpackage

// File: rtl/gfx_irq_src_cell.sv
module gfx_irq_src_cell #(
  parameter bit LEVEL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic clr_i,
  output logic st_o
);
  logic st_q;

  // source activity overrides a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= 1'b0;
    else         st_q <= (st_q & ~clr_i) | evt_i;
  end

  assign st_o = st_q;

  AST_EVT_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> st_o); // R4
  AST_PEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_o && !clr_i) |=> st_o); // R3
  AST_CLR_WORKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_o && clr_i && !evt_i) |=> !st_o); // R4

  if (LEVEL) begin : g_lvl
    AST_LVL_STICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (evt_i && clr_i) |=> st_o); // R5
  end
endmodule

// File: rtl/gfx_irq_en_reg.sv
module gfx_irq_en_reg #(
  parameter int unsigned W = 4,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] en_o
);
  logic [W-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else         en_q <= ((en_q | set_i) & ~clr_i) & MASK;
  end

  assign en_o = en_q;

  AST_ENA_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i && !(|clr_i)) |=> ((en_o & $past(set_i)) == $past(set_i))); // R6
  AST_DIS_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|clr_i) |=> ((en_o & $past(clr_i)) == '0)); // R7
  AST_ENA_ZERO_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((en_o & ~$past(set_i | clr_i)) == ($past(en_o) & ~$past(set_i | clr_i)))); // R6
endmodule

// File: rtl/gfx_irq_bus_if.sv
module gfx_irq_bus_if
  import gfx_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [SRC_W-1:0]  stat_i,
  input  logic [SRC_W-1:0]  en_i,
  output logic [SRC_W-1:0]  stat_clr_o,
  output logic [SRC_W-1:0]  en_set_o,
  output logic [SRC_W-1:0]  en_clr_o,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o
);
  reg_sel_e           sel;
  logic [SRC_W-1:0]   wbits;
  logic [DATA_W-1:0]  rdata_d;
  logic [DATA_W-1:0]  rdata_q;
  logic               rvalid_q;
  logic               wr;
  logic               unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:SRC_W];

  always_comb begin
    if      (addr_i == ADDR_W'(OFF_STAT)) sel = SEL_STAT;
    else if (addr_i == ADDR_W'(OFF_ENA))  sel = SEL_ENA;
    else if (addr_i == ADDR_W'(OFF_DIS))  sel = SEL_DIS;
    else                                  sel = SEL_NONE;
  end

  assign wr    = req_i & we_i;
  assign wbits = wdata_i[SRC_W-1:0] & SRC_MASK;

  assign stat_clr_o = (wr && sel == SEL_STAT) ? wbits : '0;
  assign en_set_o   = (wr && sel == SEL_ENA)  ? wbits : '0;
  assign en_clr_o   = (wr && sel == SEL_DIS)  ? wbits : '0;

  always_comb begin
    rdata_d = '0;
    unique case (sel)
      SEL_STAT:        rdata_d[SRC_W-1:0] = stat_i & SRC_MASK;
      SEL_ENA, SEL_DIS: rdata_d[SRC_W-1:0] = en_i & SRC_MASK;
      default:         rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= req_i & ~we_i;
      rdata_q  <= (req_i & ~we_i) ? rdata_d : '0;
    end
  end

  assign rvalid_o = rvalid_q;
  assign rdata_o  = rdata_q;

  AST_RD_UNUSED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> ((rdata_o & ~DATA_W'(SRC_MASK)) == '0)); // R2
  AST_RD_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o); // R11
  AST_WR_NO_RVALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> !rvalid_o); // R11
endmodule

// File: rtl/gfx_irq_ctrl.sv
module gfx_irq_ctrl
  import gfx_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              oom_i,
  input  logic              flush_done_i,
  input  logic              frame_done_i,
  output logic              irq_o
);
  logic [SRC_W-1:0] evt;
  logic [SRC_W-1:0] stat;
  logic [SRC_W-1:0] en;
  logic [SRC_W-1:0] stat_clr;
  logic [SRC_W-1:0] en_set;
  logic [SRC_W-1:0] en_clr;
  logic             irq_q;

  always_comb begin
    evt            = '0;
    evt[BIT_FRAME] = frame_done_i;
    evt[BIT_FLUSH] = flush_done_i;
    evt[BIT_OOM]   = oom_i;
  end

  gfx_irq_bus_if #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) i_bus_if (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .stat_i     (stat),
    .en_i       (en),
    .stat_clr_o (stat_clr),
    .en_set_o   (en_set),
    .en_clr_o   (en_clr),
    .rvalid_o   (rvalid_o),
    .rdata_o    (rdata_o)
  );

  for (genvar i = 0; i < SRC_W; i++) begin : g_src
    if (SRC_MASK[i]) begin : g_used
      gfx_irq_src_cell #(
        .LEVEL (i == BIT_OOM)
      ) i_cell (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .evt_i  (evt[i]),
        .clr_i  (stat_clr[i]),
        .st_o   (stat[i])
      );
    end else begin : g_empty
      logic unused_src;
      assign unused_src = evt[i] ^ stat_clr[i];
      assign stat[i]    = 1'b0;
    end
  end

  gfx_irq_en_reg #(
    .W    (SRC_W),
    .MASK (SRC_MASK)
  ) i_en_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (en_set),
    .clr_i  (en_clr),
    .en_o   (en)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(stat & en);
  end

  assign irq_o = irq_q;

  AST_IRQ_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(stat & en)) |=> irq_o); // R10
  AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(stat & en)) |=> !irq_o); // R10
  AST_LATCH_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_done_i && !en[BIT_FLUSH]) |=> stat[BIT_FLUSH]); // R9
  AST_OOM_VISIBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oom_i |=> stat[BIT_OOM]); // R5
endmodule

// File: tb/test_gfx_irq_ctrl.sv
module test_gfx_irq_ctrl;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 4;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_i = 1'b0;
  logic              we_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [DATA_W-1:0] wdata_i = '0;
  logic              rvalid_o;
  logic [DATA_W-1:0] rdata_o;
  logic              oom_i = 1'b0;
  logic              flush_done_i = 1'b0;
  logic              frame_done_i = 1'b0;
  logic              irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [DATA_W-1:0] exp_q[$];
  string             tag_q[$];

  gfx_irq_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_gfx_irq_ctrl (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
    .rvalid_o, .rdata_o, .oom_i, .flush_done_i, .frame_done_i, .irq_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic check(input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // driver: push the expected read result, then issue the read
  task automatic rd(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    tick();
    req_i = 1'b0;
    tick();
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    tick();
    req_i = 1'b0; we_i = 1'b0; wdata_i = '0;
  endtask

  task automatic irq_chk(input logic exp, input string tag);
    tick(); tick();
    check(tag, DATA_W'(irq_o), DATA_W'(exp));
  endtask

  // monitor: compare each returned read against the scoreboard
  always @(negedge clk_i) begin
    if (rst_ni && rvalid_o) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R11: unexpected read data 0x%0h expected none", rdata_o);
      end else begin
        check(tag_q.pop_front(), rdata_o, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    check("R1 irq in reset", DATA_W'(irq_o), '0);
    rst_ni = 1'b1;
    tick();
    check("R1 irq after reset", DATA_W'(irq_o), '0);
    rd(4'h0, 32'h0, "R1 status after reset");
    rd(4'h4, 32'h0, "R1 enable after reset");
    rd(4'hC, 32'h0, "R2 unmapped offset");

    // flush event with the source masked
    flush_done_i = 1'b1; tick(); flush_done_i = 1'b0;
    rd(4'h0, 32'h2, "R9 flush latched while disabled");
    irq_chk(1'b0, "R10 masked pending gives no irq");
    wr(4'h0, 32'h0);
    rd(4'h0, 32'h2, "R3 write of zero keeps flush");
    wr(4'h0, 32'h1);
    rd(4'h0, 32'h2, "R3 clear of other bit keeps flush");

    // enable aliases
    wr(4'h4, 32'h2);
    rd(4'h4, 32'h2, "R6 set-enable flush");
    rd(4'h8, 32'h2, "R8 clear-enable alias reads mask");
    irq_chk(1'b1, "R10 pending and enabled raises irq");
    wr(4'h4, 32'h8);
    rd(4'h4, 32'hA, "R6 zero bits ignored on set");
    wr(4'h4, 32'hFFFF_FFFF);
    rd(4'h8, 32'hB, "R2 unused enable bits read zero");
    wr(4'h8, 32'h1);
    rd(4'h4, 32'hA, "R7 clear-enable frame");
    wr(4'h8, 32'h0);
    rd(4'h8, 32'hA, "R7 zero bits ignored on clear");

    // clear flush
    wr(4'h0, 32'h2);
    rd(4'h0, 32'h0, "R4 write-1 clears flush");
    irq_chk(1'b0, "R10 irq drops after clear");

    // event racing a clear
    frame_done_i = 1'b1; tick();
    wr(4'h0, 32'h1);
    frame_done_i = 1'b0;
    rd(4'h0, 32'h1, "R4 event wins over same-cycle clear");
    wr(4'h0, 32'h1);
    rd(4'h0, 32'h0, "R3 frame cleared by write-1");

    // out-of-memory level
    oom_i = 1'b1; tick();
    rd(4'h0, 32'h8, "R5 oom pending while level high");
    irq_chk(1'b1, "R10 oom raises irq");
    wr(4'h0, 32'h8);
    rd(4'h0, 32'h8, "R5 oom clear ignored while level high");
    wr(4'h8, 32'h8);
    irq_chk(1'b0, "R7 masking oom drops irq");
    rd(4'h0, 32'h8, "R9 oom pending while masked");
    oom_i = 1'b0; tick();
    rd(4'h0, 32'h8, "R5 oom held after level falls");
    wr(4'h0, 32'h8);
    rd(4'h0, 32'h0, "R5 oom cleared after level falls");
    wr(4'h4, 32'h8);
    irq_chk(1'b0, "R10 re-enable with nothing pending");

    // all sources
    frame_done_i = 1'b1; flush_done_i = 1'b1; oom_i = 1'b1; tick();
    frame_done_i = 1'b0; flush_done_i = 1'b0; oom_i = 1'b0; tick();
    rd(4'h0, 32'hB, "R2 all sources at their bit positions");
    wr(4'h4, 32'hB);
    irq_chk(1'b1, "R10 all enabled");
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, 32'h0, "R4 clear all");
    irq_chk(1'b0, "R10 irq low after clear all");

    tick();
    check("R11 all reads returned", DATA_W'(exp_q.size()), '0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule